// File: doc/BRIEF.md
# DRAM Low-Power Clock-Enable Sequencer

This block sits on the controller side of a DDR2-class memory interface and owns the clock-enable line. When the scheduler signals that it has nothing to issue, the block drops the clock enable and the device goes into its low-power state. If the block only reaches that decision while a burst is running, or while a refresh is owed, it waits instead. The flavour of the low-power state follows the bank status sampled at the moment of entry. With no row open, the result is a precharged power-down. With at least one row open, it is an active power-down.

While the device is powered down, the block ignores bank status and burst status, since the command and address pins carry no meaning then. It holds the clock enable low until the scheduler withdraws its idle request or a refresh becomes due, and then raises the clock enable again. For a fixed number of cycles after any rise of the clock enable, it asserts a command-block output. This makes the scheduler keep the command bus at NOP while the device wakes. After reset, the block performs the same wake sequence before any command may issue.

Top module: `pd_cke_ctrl`

## Requirements
- R1: While reset is asserted, `cke` is 0, `pd_status` is 2'b00 and `cmd_block` is 1.
- R2: On the first clock edge after reset is released, `cke` rises. `cmd_block` stays 1 for exactly EXIT_GAP (default 2) cycles after that rise and then falls, with `pd_status` at 2'b00 throughout.
- R3: In normal operation with no wake window pending, an edge that samples `idle_req`=1, `burst_busy`=0, `refresh_due`=0 and `bank_open`=0 drives `cke` to 0 and `pd_status` to 2'b01 (precharged power-down).
- R4: Under the same entry conditions with any `bank_open` bit at 1, `pd_status` becomes 2'b10 (active power-down).
- R5: An edge that samples `burst_busy`=1 in normal operation never drops `cke`.
- R6: An edge that samples `refresh_due`=1 in normal operation never drops `cke`.
- R7: In power-down, an edge that samples `idle_req`=1 and `refresh_due`=0 keeps `cke` at 0 and `pd_status` unchanged, whatever `bank_open` and `burst_busy` hold.
- R8: In power-down, an edge that samples `refresh_due`=1 raises `cke` and sets `pd_status` to 2'b11 (waking).
- R9: In power-down, an edge that samples `idle_req`=0 raises `cke` and sets `pd_status` to 2'b11.
- R10: `cmd_block` is 1 whenever `cke` is 0. After a wake, it stays 1 for EXIT_GAP cycles after `cke` rises and falls on the same edge that returns `pd_status` to 2'b00.
- R11: The block never re-enters power-down before `cmd_block` has fallen. With `idle_req` held at 1 through a wake, the earliest re-entry is the edge after `pd_status` returns to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req | input | 1 | Scheduler has nothing to issue and requests power-down |
| bank_open | input | NUM_BANKS | One bit per bank, set while that bank has a row open |
| burst_busy | input | 1 | A read or write burst is in progress |
| refresh_due | input | 1 | A refresh must be serviced |
| cke | output | 1 | Registered clock-enable to the memory device |
| cmd_block | output | 1 | Registered; scheduler must issue only NOP while high |
| pd_status | output | 2 | Registered mode: 00 normal, 01 precharged power-down, 10 active power-down, 11 waking |

## Verification
All three outputs come from registers, so every response lands on the clock edge that samples the stimulus. A drop or rise of `cke` and the new `pd_status` are therefore visible one edge after the inputs are applied. The release of `cmd_block` follows EXIT_GAP edges after the rise of `cke`. The bench drives inputs on the falling edge, advances its own model on the rising edge with those same inputs, and compares all three outputs on the next falling edge. This means each check sits exactly one register stage after its cause, and the wake window is tracked cycle by cycle by a countdown in the model.

// File: rtl/pd_cke_pkg.sv
// Package: shared state encoding for the clock-enable sequencer.
// The state value doubles as the externally visible status code, so the
// encodings below are part of the block's interface.
package pd_cke_pkg;

    typedef enum logic [1:0] {
        PD_ST_NORMAL = 2'b00,
        PD_ST_PRECHG = 2'b01,
        PD_ST_ACTIVE = 2'b10,
        PD_ST_WAKING = 2'b11
    } pd_state_t;

endpackage

// File: rtl/pd_entry_gate.sv
// Module: pd_entry_gate
// Purely combinational qualification of the power-down request.
// Determines whether any bank holds an open row, whether entry is legal
// this cycle, and whether an existing power-down must be left.
// Assumes inputs are synchronous to the controller clock.
module pd_entry_gate #(
    parameter int NUM_BANKS = 8
) (
    input  logic                 idle_req,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 burst_busy,
    input  logic                 refresh_due,
    output logic                 any_open,
    output logic                 entry_ok,
    output logic                 exit_req
);

    logic [NUM_BANKS:0] open_chain;

    assign open_chain[0] = 1'b0;

    // Ripple OR of the per-bank open flags.
    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_open
            assign open_chain[b+1] = open_chain[b] | bank_open[b];
        end
    endgenerate

    assign any_open = open_chain[NUM_BANKS];

    // Entry needs an idle request, no burst in flight and no refresh owed.
    assign entry_ok = idle_req & ~burst_busy & ~refresh_due;

    // Leaving power-down on withdrawn request or pending refresh.
    assign exit_req = ~idle_req | refresh_due;

endmodule

// File: rtl/pd_gap_timer.sv
// Module: pd_gap_timer
// Countdown that spans the command-free window after the clock enable
// rises. A load sets the count to GAP; it then falls by one per cycle.
// Assumes GAP >= 1. busy_nxt predicts busy after the coming edge so that
// the parent can register its block output without an extra stage.
module pd_gap_timer #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic busy_nxt,
    output logic last
);

    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] GAP_V = CW'(GAP);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    logic [CW-1:0] cnt_q;

    // Load or decrement the remaining window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= GAP_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE_V;
        end
    end

    assign busy     = (cnt_q != '0);
    assign last     = (cnt_q == ONE_V);
    assign busy_nxt = load | (cnt_q > ONE_V);

endmodule

// File: rtl/pd_cke_ctrl.sv
// Module: pd_cke_ctrl (top)
// Drives the clock enable of a DDR2-class device into and out of
// power-down. Picks precharged or active power-down from bank status at
// entry, refuses entry during bursts or when refresh is owed, leaves
// power-down when the idle request drops or refresh is due, and holds
// the scheduler at NOP for EXIT_GAP cycles after every clock-enable rise
// (including the one after reset). All outputs are registered.
// Assumes EXIT_GAP >= 1 and synchronous inputs.
module pd_cke_ctrl
    import pd_cke_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int EXIT_GAP  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idle_req,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 burst_busy,
    input  logic                 refresh_due,
    output logic                 cke,
    output logic                 cmd_block,
    output logic [1:0]           pd_status
);

    pd_state_t state_q, state_n;
    logic      cke_q, cke_n;
    logic      block_q, block_n;
    logic      any_open, entry_ok, exit_req;
    logic      gap_load, gap_busy, gap_busy_nxt, gap_last;

    pd_entry_gate #(
        .NUM_BANKS (NUM_BANKS)
    ) u_gate (
        .idle_req    (idle_req),
        .bank_open   (bank_open),
        .burst_busy  (burst_busy),
        .refresh_due (refresh_due),
        .any_open    (any_open),
        .entry_ok    (entry_ok),
        .exit_req    (exit_req)
    );

    pd_gap_timer #(
        .GAP (EXIT_GAP)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .busy     (gap_busy),
        .busy_nxt (gap_busy_nxt),
        .last     (gap_last)
    );

    // Next-state, next-CKE and wake-window launch decisions.
    always_comb begin
        state_n  = state_q;
        cke_n    = cke_q;
        gap_load = 1'b0;
        unique case (state_q)
            PD_ST_NORMAL: begin
                if (!cke_q) begin
                    cke_n    = 1'b1;
                    gap_load = 1'b1;
                end else if (entry_ok && !gap_busy) begin
                    cke_n   = 1'b0;
                    state_n = any_open ? PD_ST_ACTIVE : PD_ST_PRECHG;
                end
            end
            PD_ST_PRECHG, PD_ST_ACTIVE: begin
                if (exit_req) begin
                    cke_n    = 1'b1;
                    gap_load = 1'b1;
                    state_n  = PD_ST_WAKING;
                end
            end
            PD_ST_WAKING: begin
                if (gap_last) begin
                    state_n = PD_ST_NORMAL;
                end
            end
            default: state_n = PD_ST_NORMAL;
        endcase
    end

    // Command block follows the values the registers take at the edge.
    always_comb begin
        block_n = !cke_n || (state_n != PD_ST_NORMAL) || gap_busy_nxt;
    end

    // Output and state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PD_ST_NORMAL;
            cke_q   <= 1'b0;
            block_q <= 1'b1;
        end else begin
            state_q <= state_n;
            cke_q   <= cke_n;
            block_q <= block_n;
        end
    end

    assign cke       = cke_q;
    assign cmd_block = block_q;
    assign pd_status = state_q;

endmodule

// File: rtl/pd_cke_ctrl_checker.sv
// Module: pd_cke_ctrl_checker
// Port-level temporal checks for pd_cke_ctrl, attached with bind.
module pd_cke_ctrl_checker #(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 idle_req,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 burst_busy,
    input logic                 refresh_due,
    input logic                 cke,
    input logic                 cmd_block,
    input logic [1:0]           pd_status
);

    logic in_pd;
    assign in_pd = (pd_status == 2'b01) || (pd_status == 2'b10);

    assert_entry_no_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(burst_busy));

    assert_entry_no_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(refresh_due));

    assert_precharged_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && ($past(bank_open) == '0)) |-> (pd_status == 2'b01));

    assert_active_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && ($past(bank_open) != '0)) |-> (pd_status == 2'b10));

    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pd && idle_req && !refresh_due) |=> (!cke && $stable(pd_status)));

    assert_refresh_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pd && refresh_due) |=> (cke && pd_status == 2'b11));

    assert_idle_drop_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pd && !idle_req) |=> (cke && pd_status == 2'b11));

    assert_block_while_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd_block);

    assert_block_after_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cmd_block);

    assert_no_early_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(cmd_block));

endmodule

bind pd_cke_ctrl pd_cke_ctrl_checker #(
    .NUM_BANKS (NUM_BANKS)
) u_pd_cke_ctrl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .bank_open   (bank_open),
    .burst_busy  (burst_busy),
    .refresh_due (refresh_due),
    .cke         (cke),
    .cmd_block   (cmd_block),
    .pd_status   (pd_status)
);

// File: tb/tb_pd_cke_ctrl.sv
// Bench: tb_pd_cke_ctrl
// Directed corner cases plus seeded random stimulus, checked each cycle
// against a requirement-level model kept in the bench.
module tb_pd_cke_ctrl;

    localparam int NB  = 8;
    localparam int GAP = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          idle_req;
    logic [NB-1:0] bank_open;
    logic          burst_busy;
    logic          refresh_due;
    logic          cke;
    logic          cmd_block;
    logic [1:0]    pd_status;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Expected-behaviour model state.
    logic m_cke;
    int   m_st;
    int   m_left;

    always #2.5 clk = ~clk;

    pd_cke_ctrl #(.NUM_BANKS(NB), .EXIT_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .bank_open(bank_open),
        .burst_busy(burst_busy), .refresh_due(refresh_due),
        .cke(cke), .cmd_block(cmd_block), .pd_status(pd_status)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_block();
        return !m_cke || (m_st != 0) || (m_left != 0);
    endfunction

    // Advance the model by one edge using the sampled inputs.
    function automatic string model_edge(logic i_idle, logic [NB-1:0] i_bank,
                                         logic i_burst, logic i_ref);
        string tag;
        tag = "R11";
        if (m_st == 0 && !m_cke) begin
            m_cke = 1'b1; m_left = GAP; tag = "R2";
        end else if (m_st == 0) begin
            if (m_left == 0 && i_idle && !i_burst && !i_ref) begin
                m_cke = 1'b0;
                m_st  = (i_bank != '0) ? 2 : 1;
                tag   = (m_st == 2) ? "R4" : "R3";
            end else begin
                if (m_left > 0) begin m_left--; tag = "R2"; end
                else if (i_idle && i_burst) tag = "R5";
                else if (i_idle && i_ref)   tag = "R6";
            end
        end else if (m_st == 1 || m_st == 2) begin
            if (i_ref) begin
                m_cke = 1'b1; m_st = 3; m_left = GAP; tag = "R8";
            end else if (!i_idle) begin
                m_cke = 1'b1; m_st = 3; m_left = GAP; tag = "R9";
            end else tag = "R7";
        end else begin
            m_left--;
            if (m_left == 0) m_st = 0;
            tag = "R10";
        end
        return tag;
    endfunction

    task automatic step();
        string tag;
        @(posedge clk);
        tag = model_edge(idle_req, bank_open, burst_busy, refresh_due);
        @(negedge clk);
        check(tag, "cke", int'(cke), int'(m_cke));
        check(tag, "pd_status", int'(pd_status), m_st);
        check(tag, "cmd_block", int'(cmd_block), int'(exp_block()));
    endtask

    task automatic drive(logic i, logic [NB-1:0] b, logic u, logic r);
        idle_req = i; bank_open = b; burst_busy = u; refresh_due = r;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b1, '0, 1'b0, 1'b0);
        m_cke = 1'b0; m_st = 0; m_left = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "cke", int'(cke), 0);
        check("R1", "pd_status", int'(pd_status), 0);
        check("R1", "cmd_block", int'(cmd_block), 1);
        rst_n = 1'b1;

        // R2: wake after reset with entry requested but blocked by burst (R5).
        drive(1'b1, '0, 1'b1, 1'b0);
        repeat (5) step();
        // R6: refresh owed blocks entry.
        drive(1'b1, '0, 1'b0, 1'b1);
        repeat (2) step();
        // R3: precharged entry, then R7 hold while don't-care inputs move.
        drive(1'b1, '0, 1'b0, 1'b0);
        step();
        drive(1'b1, 8'hA5, 1'b1, 1'b0); step();
        drive(1'b1, 8'h00, 1'b0, 1'b0); step();
        // R8: refresh forces wake; R10/R11 with idle held through window.
        drive(1'b1, '0, 1'b0, 1'b1); step();
        drive(1'b1, 8'h10, 1'b0, 1'b0);
        repeat (4) step();
        // R4 entered above with an open row; R9 idle drop wakes.
        drive(1'b0, 8'h10, 1'b0, 1'b0);
        repeat (4) step();

        // Seeded random stimulus.
        void'($urandom(32'd1234));
        for (int k = 0; k < 4000; k++) begin
            drive(($urandom % 8) != 0,
                  (($urandom % 2) == 0) ? '0 : NB'($urandom),
                  ($urandom % 5) == 0,
                  ($urandom % 12) == 0);
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule